// File: doc/BRIEF.md
# PCIe Error Status Logger

This block gathers error events reported by a PCIe transaction layer and keeps them in registers laid out in the style of advanced error reporting. It holds uncorrectable and correctable status words, their mask words, an uncorrectable severity word, a root status word with its reporting enables, a first-error pointer and a captured TLP header. Each event input is a one-cycle pulse. Uncorrectable events may come with a header, which is flagged by a valid bit.

Software reaches every register through a small local bus. The bus has an address, separate read and write strobes, and write and read data. Status words are cleared by writing ones. Three sticky sideband flags tell the application that something is waiting in the uncorrectable, correctable or root status word. Separate real-time outputs echo every event for one cycle. These outputs ignore the mask and severity settings, so the application sees each event even when logging is turned off. Poisoned TLPs only produce a real-time pulse and leave every register untouched.

Top module: `pcie_err_logger`

## Requirements
- R1: After reset every register reads zero, all three sideband flags are low and every real-time output is low.
- R2: An uncorrectable event on bit i with mask bit i clear sets bit i of the uncorrectable status word (address 0). The bit stays set until software writes a 1 to that bit at address 0. Writing 0 to a bit has no effect.
- R3: A correctable event on bit i with mask bit i clear sets bit i of the correctable status word (address 3). The bit stays set until software writes a 1 to it. Writing 0 to a bit has no effect.
- R4: An event whose mask bit is 1 sets no status bit, raises no flag and changes neither the pointer nor the header log. The uncorrectable mask is at address 1 and the correctable mask is at address 4.
- R5: rt_unc_o and rt_cor_o repeat the event vectors on the cycle after they arrive, whatever the mask and severity settings are. The uncorrectable bits mean: bit 0 data link error, bit 1 malformed TLP, bit 2 receive credit overflow (TLP dropped), bit 3 internal error.
- R6: unc_flag_o and cor_flag_o go high on the cycle after their status word becomes nonzero. Each goes low on the cycle after its status word returns to zero.
- R7: The first-error pointer (address 5) and the header log (addresses 8 to 11, address 8 holding hdr_i[31:0]) are loaded only when an unmasked uncorrectable event arrives while no unmasked uncorrectable status bit is pending. The pointer takes the lowest event index in that cycle. The header log takes hdr_i, or zero when hdr_vld_i is low. At all other times both keep their value.
- R8: A poisoned-TLP pulse gives a one-cycle pulse on rt_poison_o on the next cycle and sets no register.
- R9: Root status (address 6, write-1-to-clear) logs bit 0 for an unmasked correctable event, bit 1 for an unmasked non-fatal uncorrectable event and bit 2 for an unmasked fatal one. Severity bit 1 at address 2 means fatal. Each root bit is logged only when the matching enable bit at address 7 is set. root_flag_o follows the timing of R6.
- R10: bus_rdata_o carries the addressed register on the cycle after bus_rd_i, holding the value from before that edge. Mask, severity and enable words read back the bits written, limited to their widths. Writes to the pointer and header addresses are ignored.
- R11: When a write-1-to-clear and a new event hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unc_evt_i | input | UNC_W | Uncorrectable event pulses |
| cor_evt_i | input | COR_W | Correctable event pulses |
| poison_evt_i | input | 1 | Poisoned TLP pulse |
| hdr_vld_i | input | 1 | hdr_i belongs to this cycle's event |
| hdr_i | input | HDR_W | TLP header of the event |
| bus_addr_i | input | 4 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the strobe |
| unc_flag_o | output | 1 | Uncorrectable status pending |
| cor_flag_o | output | 1 | Correctable status pending |
| root_flag_o | output | 1 | Root status pending |
| rt_unc_o | output | UNC_W | Real-time uncorrectable pulses |
| rt_cor_o | output | COR_W | Real-time correctable pulses |
| rt_poison_o | output | 1 | Real-time poisoned TLP pulse |

## Verification
The bench drives every event bit both masked and unmasked. A design that let the mask gate the real-time outputs would drop pulses, and one that ignored the mask would set status bits or move the pointer. It orders errors so that a second error arrives while the first is still pending, then clears only part of the status. A logger that recaptured on every event, or that looked only at the newest bit, would overwrite the header log. It also checks the exact cycle the flags fall after a clear, that a clear and an event in the same cycle leave the bit set, and that the lowest index wins when several errors arrive in one cycle.

// File: rtl/errlog_pkg.sv
package errlog_pkg;

    localparam int WORD_W = 32;

    // register bus addresses
    localparam logic [3:0] A_UNC_STS  = 4'h0;
    localparam logic [3:0] A_UNC_MSK  = 4'h1;
    localparam logic [3:0] A_UNC_SEV  = 4'h2;
    localparam logic [3:0] A_COR_STS  = 4'h3;
    localparam logic [3:0] A_COR_MSK  = 4'h4;
    localparam logic [3:0] A_FEP      = 4'h5;
    localparam logic [3:0] A_ROOT_STS = 4'h6;
    localparam logic [3:0] A_RPT_EN   = 4'h7;
    localparam logic [3:0] A_HDR0     = 4'h8;

    // uncorrectable event bit meanings
    localparam int UNC_DLL   = 0;
    localparam int UNC_MALF  = 1;
    localparam int UNC_RXOVF = 2;
    localparam int UNC_INTL  = 3;

    // root status bits
    localparam int ROOT_COR      = 0;
    localparam int ROOT_NONFATAL = 1;
    localparam int ROOT_FATAL    = 2;
    localparam int ROOT_W        = 3;

endpackage

// File: rtl/errlog_status.sv
module errlog_status #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] sts_o,
    output logic         flag_o
);

    typedef struct packed {
        logic [W-1:0] sts;
        logic         flag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // a new event wins over a same-cycle clear
        st_d.sts  = (st_q.sts & ~clr_i) | (evt_i & ~mask_i);
        st_d.flag = |st_q.sts;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_o  = st_q.sts;
    assign flag_o = st_q.flag;

    // R2/R3: a set bit survives unless a clear hits it
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.sts & ~clr_i) != '0) |=>
        ((st_q.sts & $past(st_q.sts & ~clr_i)) == $past(st_q.sts & ~clr_i)));

    // R4: newly set bits come only from unmasked events
    p_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.sts & ~$past(st_q.sts) & ~$past(evt_i & ~mask_i)) == '0));

    // R6: flag follows a nonzero status one cycle later
    p_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sts != '0) |=> flag_o);

endmodule

// File: rtl/errlog_capture.sv
module errlog_capture #(
    parameter int W     = 8,
    parameter int HDR_W = 128,
    parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     new_i,
    input  logic             pending_i,
    input  logic             hdr_vld_i,
    input  logic [HDR_W-1:0] hdr_i,
    output logic [IDX_W-1:0] fep_o,
    output logic [HDR_W-1:0] hdr_o
);

    typedef struct packed {
        logic [IDX_W-1:0] fep;
        logic [HDR_W-1:0] hdr;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [IDX_W-1:0] low_idx;

    always_comb begin
        low_idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (new_i[i]) low_idx = IDX_W'(i);
        end
        cap_d = cap_q;
        if ((|new_i) && !pending_i) begin
            cap_d.fep = low_idx;
            cap_d.hdr = hdr_vld_i ? hdr_i : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign fep_o = cap_q.fep;
    assign hdr_o = cap_q.hdr;

    // R7: nothing is recaptured while an earlier error is pending
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pending_i |=> ($stable(hdr_o) && $stable(fep_o)));

endmodule

// File: rtl/pcie_err_logger.sv
module pcie_err_logger
    import errlog_pkg::*;
#(
    parameter int UNC_W = 8,
    parameter int COR_W = 4,
    parameter int HDR_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [UNC_W-1:0] unc_evt_i,
    input  logic [COR_W-1:0] cor_evt_i,
    input  logic             poison_evt_i,
    input  logic             hdr_vld_i,
    input  logic [HDR_W-1:0] hdr_i,
    input  logic [3:0]       bus_addr_i,
    input  logic             bus_wr_i,
    input  logic             bus_rd_i,
    input  logic [31:0]      bus_wdata_i,
    output logic [31:0]      bus_rdata_o,
    output logic             unc_flag_o,
    output logic             cor_flag_o,
    output logic             root_flag_o,
    output logic [UNC_W-1:0] rt_unc_o,
    output logic [COR_W-1:0] rt_cor_o,
    output logic             rt_poison_o
);

    localparam int IDX_W     = (UNC_W > 1) ? $clog2(UNC_W) : 1;
    localparam int HDR_WORDS = HDR_W / WORD_W;

    typedef struct packed {
        logic [UNC_W-1:0]  unc_msk;
        logic [UNC_W-1:0]  unc_sev;
        logic [COR_W-1:0]  cor_msk;
        logic [ROOT_W-1:0] rpt_en;
        logic [31:0]       rdata;
        logic [UNC_W-1:0]  rt_unc;
        logic [COR_W-1:0]  rt_cor;
        logic              rt_poison;
    } regs_t;

    regs_t r_d, r_q;

    logic [UNC_W-1:0]  unc_sts, unc_clr, unc_new;
    logic [COR_W-1:0]  cor_sts, cor_clr;
    logic [ROOT_W-1:0] root_sts, root_clr, root_evt;
    logic [IDX_W-1:0]  fep;
    logic [HDR_W-1:0]  hdr_log;
    logic              unc_pending;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata_i;

    always_comb begin
        unc_new     = unc_evt_i & ~r_q.unc_msk;
        unc_pending = |(unc_sts & ~r_q.unc_msk);
        unc_clr     = (bus_wr_i && bus_addr_i == A_UNC_STS)  ? bus_wdata_i[UNC_W-1:0]  : '0;
        cor_clr     = (bus_wr_i && bus_addr_i == A_COR_STS)  ? bus_wdata_i[COR_W-1:0]  : '0;
        root_clr    = (bus_wr_i && bus_addr_i == A_ROOT_STS) ? bus_wdata_i[ROOT_W-1:0] : '0;
        root_evt                = '0;
        root_evt[ROOT_COR]      = |(cor_evt_i & ~r_q.cor_msk);
        root_evt[ROOT_NONFATAL] = |(unc_new & ~r_q.unc_sev);
        root_evt[ROOT_FATAL]    = |(unc_new & r_q.unc_sev);
    end

    always_comb begin
        r_d           = r_q;
        r_d.rt_unc    = unc_evt_i;
        r_d.rt_cor    = cor_evt_i;
        r_d.rt_poison = poison_evt_i;
        if (bus_wr_i) begin
            case (bus_addr_i)
                A_UNC_MSK: r_d.unc_msk = bus_wdata_i[UNC_W-1:0];
                A_UNC_SEV: r_d.unc_sev = bus_wdata_i[UNC_W-1:0];
                A_COR_MSK: r_d.cor_msk = bus_wdata_i[COR_W-1:0];
                A_RPT_EN:  r_d.rpt_en  = bus_wdata_i[ROOT_W-1:0];
                default:   ;
            endcase
        end
        r_d.rdata = '0;
        if (bus_rd_i) begin
            case (bus_addr_i)
                A_UNC_STS:  r_d.rdata = 32'(unc_sts);
                A_UNC_MSK:  r_d.rdata = 32'(r_q.unc_msk);
                A_UNC_SEV:  r_d.rdata = 32'(r_q.unc_sev);
                A_COR_STS:  r_d.rdata = 32'(cor_sts);
                A_COR_MSK:  r_d.rdata = 32'(r_q.cor_msk);
                A_FEP:      r_d.rdata = 32'(fep);
                A_ROOT_STS: r_d.rdata = 32'(root_sts);
                A_RPT_EN:   r_d.rdata = 32'(r_q.rpt_en);
                default: begin
                    for (int k = 0; k < HDR_WORDS; k++) begin
                        if (bus_addr_i == 4'(A_HDR0 + k))
                            r_d.rdata = hdr_log[WORD_W*k +: WORD_W];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    errlog_status #(.W(UNC_W)) u_unc (
        .clk(clk), .rst_n(rst_n), .evt_i(unc_evt_i), .mask_i(r_q.unc_msk),
        .clr_i(unc_clr), .sts_o(unc_sts), .flag_o(unc_flag_o));

    errlog_status #(.W(COR_W)) u_cor (
        .clk(clk), .rst_n(rst_n), .evt_i(cor_evt_i), .mask_i(r_q.cor_msk),
        .clr_i(cor_clr), .sts_o(cor_sts), .flag_o(cor_flag_o));

    errlog_status #(.W(ROOT_W)) u_root (
        .clk(clk), .rst_n(rst_n), .evt_i(root_evt), .mask_i(~r_q.rpt_en),
        .clr_i(root_clr), .sts_o(root_sts), .flag_o(root_flag_o));

    errlog_capture #(.W(UNC_W), .HDR_W(HDR_W), .IDX_W(IDX_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .new_i(unc_new), .pending_i(unc_pending),
        .hdr_vld_i(hdr_vld_i), .hdr_i(hdr_i), .fep_o(fep), .hdr_o(hdr_log));

    assign bus_rdata_o = r_q.rdata;
    assign rt_unc_o    = r_q.rt_unc;
    assign rt_cor_o    = r_q.rt_cor;
    assign rt_poison_o = r_q.rt_poison;

    // R5: real-time pulses track the raw events regardless of the mask
    p_rt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_unc_o == $past(unc_evt_i)) && (rt_cor_o == $past(cor_evt_i)));

    // R8: a lone poisoned pulse leaves uncorrectable status alone
    p_poison_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (poison_evt_i && unc_evt_i == '0 && !bus_wr_i) |=> (unc_sts == $past(unc_sts)));

endmodule

// File: tb/pcie_err_logger_test.sv
module pcie_err_logger_test;
    import errlog_pkg::*;

    localparam int U = 8;
    localparam int C = 4;
    localparam int H = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [U-1:0] unc_evt = '0;
    logic [C-1:0] cor_evt = '0;
    logic poison = 1'b0, hdr_vld = 1'b0;
    logic [H-1:0] hdr = '0;
    logic [3:0] addr = '0;
    logic wr = 1'b0, rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic unc_flag, cor_flag, root_flag, rt_poison;
    logic [U-1:0] rt_unc;
    logic [C-1:0] rt_cor;

    int total = 0, bad = 0;

    // bench model, built from the requirements
    logic [U-1:0] e_unc = '0, e_umsk = '0, e_sev = '0;
    logic [C-1:0] e_cor = '0, e_cmsk = '0;
    logic [2:0]   e_root = '0, e_en = '0;
    int           e_fep = 0;
    logic [H-1:0] e_hdr = '0;

    always #10 clk = ~clk;

    pcie_err_logger #(.UNC_W(U), .COR_W(C), .HDR_W(H)) uut (
        .clk(clk), .rst_n(rst_n), .unc_evt_i(unc_evt), .cor_evt_i(cor_evt),
        .poison_evt_i(poison), .hdr_vld_i(hdr_vld), .hdr_i(hdr),
        .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .unc_flag_o(unc_flag), .cor_flag_o(cor_flag),
        .root_flag_o(root_flag), .rt_unc_o(rt_unc), .rt_cor_o(rt_cor),
        .rt_poison_o(rt_poison));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic model(input logic [U-1:0] u, input logic [C-1:0] c,
                         input logic hv, input logic [H-1:0] h, input logic [U-1:0] clr);
        logic [U-1:0] nu;
        logic [C-1:0] nc;
        nu = u & ~e_umsk;
        nc = c & ~e_cmsk;
        if (nu != '0 && (e_unc & ~e_umsk) == '0) begin
            for (int i = U - 1; i >= 0; i--) if (nu[i]) e_fep = i;
            e_hdr = hv ? h : '0;
        end
        e_unc = (e_unc & ~clr) | nu;
        e_cor = e_cor | nc;
        e_root = e_root | ({|(nu & e_sev), |(nu & ~e_sev), |nc} & e_en);
    endtask

    task automatic fire(input logic [U-1:0] u, input logic [C-1:0] c, input logic p,
                        input logic hv, input logic [H-1:0] h);
        unc_evt = u; cor_evt = c; poison = p; hdr_vld = hv; hdr = h;
        @(negedge clk);
        unc_evt = '0; cor_evt = '0; poison = 1'b0; hdr_vld = 1'b0; hdr = '0;
        model(u, c, hv, h, '0);
        chk("R5 rt_unc", 32'(rt_unc), 32'(u));
        chk("R5 rt_cor", 32'(rt_cor), 32'(c));
        chk("R8 rt_poison", 32'(rt_poison), 32'(p));
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        @(negedge clk);
        chk({tag, " R6 unc_flag"}, 32'(unc_flag), 32'(e_unc != '0));
        chk({tag, " R6 cor_flag"}, 32'(cor_flag), 32'(e_cor != '0));
        chk({tag, " R9 root_flag"}, 32'(root_flag), 32'(e_root != '0));
        bus_rd(A_UNC_STS, v);  chk({tag, " R2 unc_sts"}, v, 32'(e_unc));
        bus_rd(A_UNC_MSK, v);  chk({tag, " R10 unc_msk"}, v, 32'(e_umsk));
        bus_rd(A_UNC_SEV, v);  chk({tag, " R10 unc_sev"}, v, 32'(e_sev));
        bus_rd(A_COR_STS, v);  chk({tag, " R3 cor_sts"}, v, 32'(e_cor));
        bus_rd(A_COR_MSK, v);  chk({tag, " R10 cor_msk"}, v, 32'(e_cmsk));
        bus_rd(A_FEP, v);      chk({tag, " R7 fep"}, v, 32'(e_fep));
        bus_rd(A_ROOT_STS, v); chk({tag, " R9 root_sts"}, v, 32'(e_root));
        bus_rd(A_RPT_EN, v);   chk({tag, " R10 rpt_en"}, v, 32'(e_en));
        for (int k = 0; k < H / 32; k++) begin
            bus_rd(4'(A_HDR0 + k), v);
            chk({tag, " R7 hdr"}, v, e_hdr[32*k +: 32]);
        end
    endtask

    task automatic clear_all();
        bus_wr(A_UNC_STS, '1);
        bus_wr(A_COR_STS, '1);
        bus_wr(A_ROOT_STS, '1);
        e_unc = '0; e_cor = '0; e_root = '0;
    endtask

    function automatic logic [H-1:0] mk_hdr(input int s);
        logic [H-1:0] h;
        for (int k = 0; k < H / 32; k++) h[32*k +: 32] = 32'hA5000000 + 32'(s * 16 + k);
        return h;
    endfunction

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rt_unc", 32'(rt_unc), 0);
        chk("R1 rt_poison", 32'(rt_poison), 0);
        chk("R1 rdata", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2/R5/R6/R7: each uncorrectable bit alone, then cleared
        for (int i = 0; i < U; i++) begin
            fire(U'(1) << i, '0, 1'b0, 1'b1, mk_hdr(i));
            check_all("R2 sweep");
            bus_wr(A_UNC_STS, 32'h0);
            bus_rd(A_UNC_STS, v); chk("R2 write0 no effect", v, 32'(e_unc));
            bus_wr(A_UNC_STS, 32'(U'(1) << i));
            e_unc = '0;
            chk("R6 flag held one cycle", 32'(unc_flag), 1);
            @(negedge clk);
            chk("R6 flag falls", 32'(unc_flag), 0);
        end

        // R3: each correctable bit
        for (int i = 0; i < C; i++) begin
            fire('0, C'(1) << i, 1'b0, 1'b0, '0);
            check_all("R3 sweep");
            bus_wr(A_COR_STS, 32'(C'(1) << i));
            e_cor = '0;
            chk("R6 cor flag held", 32'(cor_flag), 1);
            @(negedge clk);
            chk("R6 cor flag falls", 32'(cor_flag), 0);
        end

        // R4: masked events still pulse but log nothing
        for (int i = 0; i < U; i++) begin
            bus_wr(A_UNC_MSK, 32'(U'(1) << i)); e_umsk = U'(1) << i;
            fire(U'(1) << i, '0, 1'b0, 1'b1, mk_hdr(40 + i));
            check_all("R4 unc mask");
        end
        for (int i = 0; i < C; i++) begin
            bus_wr(A_COR_MSK, 32'(C'(1) << i)); e_cmsk = C'(1) << i;
            fire('0, C'(1) << i, 1'b0, 1'b0, '0);
            check_all("R4 cor mask");
        end
        bus_wr(A_UNC_MSK, 0); e_umsk = '0;
        bus_wr(A_COR_MSK, 0); e_cmsk = '0;

        // R7: first-error capture ordering
        fire(U'(1) << UNC_INTL, '0, 1'b0, 1'b1, mk_hdr(60));
        fire(U'(1) << 5, '0, 1'b0, 1'b1, mk_hdr(61));
        check_all("R7 second held");
        bus_wr(A_UNC_STS, 32'(U'(1) << UNC_INTL));
        e_unc = e_unc & ~(U'(1) << UNC_INTL);
        fire(U'(1) << UNC_MALF, '0, 1'b0, 1'b1, mk_hdr(62));
        check_all("R7 partial clear");
        clear_all();
        fire(U'(1) << 6 | U'(1) << UNC_RXOVF, '0, 1'b0, 1'b1, mk_hdr(63));
        check_all("R7 lowest index");
        clear_all();
        fire(U'(1) << UNC_DLL, '0, 1'b0, 1'b0, mk_hdr(64));
        check_all("R7 no header");
        clear_all();

        // R8: poisoned TLP logs nothing
        fire('0, '0, 1'b1, 1'b1, mk_hdr(70));
        check_all("R8 poison");

        // R9: root logging by severity and enables
        bus_wr(A_UNC_SEV, 32'(U'(1) << UNC_MALF)); e_sev = U'(1) << UNC_MALF;
        fire(U'(1) << UNC_MALF, 1, 1'b0, 1'b0, '0);
        check_all("R9 disabled");
        clear_all();
        bus_wr(A_RPT_EN, 32'h7); e_en = 3'h7;
        fire(U'(1) << UNC_MALF, '0, 1'b0, 1'b0, '0);
        check_all("R9 fatal");
        fire(U'(1) << UNC_DLL, '0, 1'b0, 1'b0, '0);
        fire('0, 4'h2, 1'b0, 1'b0, '0);
        check_all("R9 all");
        bus_wr(A_ROOT_STS, 32'h7); e_root = '0;
        chk("R9 root flag held", 32'(root_flag), 1);
        @(negedge clk);
        chk("R9 root flag falls", 32'(root_flag), 0);
        clear_all();
        @(negedge clk);

        // R11: clear and new event on the same bit in one cycle
        fire(U'(1) << 4, '0, 1'b0, 1'b0, '0);
        addr = A_UNC_STS; wdata = 32'(U'(1) << 4); wr = 1'b1;
        unc_evt = U'(1) << 4;
        @(negedge clk);
        wr = 1'b0; wdata = '0; unc_evt = '0;
        model(U'(1) << 4, '0, 1'b0, '0, U'(1) << 4);
        check_all("R11 set wins");
        clear_all();

        // R10: width-limited readback, read-only addresses ignore writes
        bus_wr(A_UNC_MSK, 32'hFFFFFFFF); e_umsk = '1;
        bus_wr(A_COR_MSK, 32'hFFFFFFFF); e_cmsk = '1;
        bus_wr(A_RPT_EN, 32'hFFFFFFFF);  e_en = '1;
        bus_wr(A_FEP, 32'hFFFFFFFF);
        bus_wr(A_HDR0, 32'hFFFFFFFF);
        check_all("R10 readback");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule